// File: doc/BRIEF.md
# Prescaled Event Timer

This block is an 8-bit up-counter for timing software loops and for counting external events. It counts either pulses on an instruction-cycle tick input or edges on an external count pin, whichever the control byte selects. An optional power-of-two prescaler can divide the selected event stream before it reaches the counter. When the counter rolls over from 255 to 0, the block emits a one-cycle overflow pulse and sets a sticky overflow flag. That flag stays set until a dedicated clear input drops it.

The same control byte holds three more things. One bit selects which edge of an interrupt request pin is reported. The block turns that edge into a one-cycle pulse for the interrupt logic outside it. A further bit shows whether interrupts are currently enabled, and this bit is read-only: two event inputs from the core set and clear it. Both the external count pin and the interrupt pin pass through a synchroniser of configurable depth before their edges are detected.

The register port is plain and has no valid/ready handshake. It accepts one write on every cycle in which `reg_wr` is high and never stalls, so the block applies no back-pressure. `reg_rdata` shows the selected register combinationally.

Top module: `evt_timer`

## Requirements
- R1: After reset, the control byte reads 0x00, the counter reads 0x00, and `ovf_flag` and `ovf_pulse` are both 0.
- R2: A write with `reg_sel`=0 stores data bits 7 and 5..0 into the control byte. Bit 6 of the control byte is not changed by any write.
- R3: Control bit 6 becomes 1 one cycle after `ie_set` and 0 one cycle after `ie_clr`. When both are high in the same cycle, `ie_clr` wins.
- R4: When control bit 5 is 0 and bit 3 is 0, each cycle with `cyc_tick` high adds 1 to the counter.
- R5: When control bit 5 is 1 and bit 4 is 0, each rising edge of the synchronised `cnt_pin` is one event, and `cyc_tick` is ignored.
- R6: When control bit 5 is 1 and bit 4 is 1, each falling edge of the synchronised `cnt_pin` is one event, and rising edges are ignored.
- R7: When control bit 3 is 1, the counter advances once per 2^(k+1) selected events, where k is the 3-bit code in control bits 2..0.
- R8: When the counter advances from 255, it reads 0. In that same cycle `ovf_pulse` is high for exactly one cycle and `ovf_flag` becomes 1. The flag then holds until a cycle with `ovf_clr` high and no new wrap. If a wrap and `ovf_clr` fall in the same cycle, the flag stays 1.
- R9: Any register write clears the prescaler's event count. A counter write (`reg_sel`=1) loads the written value and overrides an increment in the same cycle.
- R10: `irq_edge` pulses for one cycle on a rising edge of the synchronised `irq_pin` when control bit 7 is 0, and on a falling edge when bit 7 is 1. The other edge gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_sel | input | 1 | Register select: 0 = control byte, 1 = counter |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| cyc_tick | input | 1 | Instruction-cycle tick, internal event source |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| irq_pin | input | 1 | Interrupt request pin (asynchronous) |
| irq_edge | output | 1 | One-cycle pulse on the selected interrupt edge |
| ie_set | input | 1 | Enable or return-from-interrupt event; sets the status bit |
| ie_clr | input | 1 | Disable or acknowledge event; clears the status bit |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| ovf_pulse | output | 1 | One-cycle pulse on counter wrap |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench goes through every prescaler code with an event count chosen so that an off-by-one divisor shows up as a different final count. It also checks the top code at exactly 255 events, where a wrong divisor would already have moved the counter. In external mode it gives one more rising edge than falling edges while keeping `cyc_tick` high, so a swapped edge polarity or a leaking internal source changes the result. It also drives the races between a wrap and a flag clear, and between an increment and a counter load. A prescaler that keeps its partial count across a reconfiguration shows up as an early increment. The read-only status bit is tested by writing all ones and then all zeros and comparing the readback.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic       irq_fall;
    logic       ie;
    logic       src_ext;
    logic       cnt_fall;
    logic       pre_on;
    logic [2:0] pre_code;
  } ctrl_t;

  typedef enum logic {
    SEL_CTRL  = 1'b0,
    SEL_COUNT = 1'b1
  } regsel_e;
endpackage

// File: rtl/evt_timer_sync.sv
module evt_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rise = sh_q[STAGES-1] & ~prev_q;
  assign fall = ~sh_q[STAGES-1] & prev_q;
endmodule

// File: rtl/evt_timer_prescale.sv
module evt_timer_prescale #(
  parameter int CODE_W = 3,
  localparam int PW = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              enable,
  input  logic [CODE_W-1:0] code,
  input  logic              event_in,
  output logic              inc_out,
  output logic [PW-1:0]     pre_cnt
);
  logic [PW-1:0] mask;
  logic          hit;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PW; i++) begin
      mask[i] = (i <= int'(code));
    end
  end

  assign hit     = event_in && ((pre_cnt & mask) == mask);
  assign inc_out = enable ? hit : event_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (clear || !enable || hit) begin
      pre_cnt <= '0;
    end else if (event_in) begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/evt_timer_count.sv
module evt_timer_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  input  logic         ovf_clr,
  output logic [W-1:0] cnt,
  output logic         ovf_pulse,
  output logic         ovf_flag
);
  logic wrap;

  assign wrap = inc && !load && (cnt == {W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      ovf_pulse <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      if (load)     cnt <= load_val;
      else if (inc) cnt <= cnt + 1'b1;
      ovf_pulse <= wrap;
      if (wrap)         ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_CODE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cyc_tick,
  input  logic              cnt_pin,
  input  logic              irq_pin,
  output logic              irq_edge,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              ovf_clr,
  output logic              ovf_pulse,
  output logic              ovf_flag
);
  localparam int PW = 1 << PRE_CODE_W;

  ctrl_t             ctrl_q;
  logic              ie_q;
  logic [DATA_W-1:0] cnt_q;
  logic [PW-1:0]     pre_cnt;
  logic              cnt_rise, cnt_fall, irq_rise, irq_fall;
  logic              ext_ev, sel_ev, inc;
  logic              wr_ctrl, wr_cnt;

  assign wr_ctrl = reg_wr && (regsel_e'(reg_sel) == SEL_CTRL);
  assign wr_cnt  = reg_wr && (regsel_e'(reg_sel) == SEL_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_t'(reg_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ie_q <= 1'b0;
    else if (ie_clr) ie_q <= 1'b0;
    else if (ie_set) ie_q <= 1'b1;
  end

  evt_timer_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .din(cnt_pin), .rise(cnt_rise), .fall(cnt_fall)
  );

  evt_timer_sync #(.STAGES(SYNC_STAGES)) u_irq_sync (
    .clk(clk), .rst_n(rst_n), .din(irq_pin), .rise(irq_rise), .fall(irq_fall)
  );

  assign irq_edge = ctrl_q.irq_fall ? irq_fall : irq_rise;
  assign ext_ev   = ctrl_q.cnt_fall ? cnt_fall : cnt_rise;
  assign sel_ev   = ctrl_q.src_ext ? ext_ev : cyc_tick;

  evt_timer_prescale #(.CODE_W(PRE_CODE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(reg_wr), .enable(ctrl_q.pre_on),
    .code(ctrl_q.pre_code), .event_in(sel_ev), .inc_out(inc), .pre_cnt(pre_cnt)
  );

  evt_timer_count #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(wr_cnt), .load_val(reg_wdata), .inc(inc),
    .ovf_clr(ovf_clr), .cnt(cnt_q), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag)
  );

  always_comb begin
    if (regsel_e'(reg_sel) == SEL_COUNT) begin
      reg_rdata = cnt_q;
    end else begin
      reg_rdata    = DATA_W'(ctrl_q);
      reg_rdata[6] = ie_q;
    end
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CW = 8,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_sel,
  input logic          ie_set,
  input logic          ie_clr,
  input logic          ie,
  input logic [CW-1:0] cnt,
  input logic [PW-1:0] pre,
  input logic          ovf_clr,
  input logic          ovf_pulse,
  input logic          ovf_flag
);
  AST_RO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && !ie_set && !ie_clr) |=> (ie == $past(ie))); // R2
  AST_IE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ie_clr |=> !ie); // R3
  AST_IE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_set && !ie_clr) |=> ie); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R4
  AST_OVF_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse); // R8
  AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (cnt == '0 && ovf_flag)); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R8
  AST_PRE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (pre == '0)); // R9
endmodule

bind evt_timer evt_timer_chk #(.CW(8), .PW(1 << PRE_CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .ie_set(ie_set), .ie_clr(ie_clr), .ie(ie_q), .cnt(cnt_q), .pre(pre_cnt),
  .ovf_clr(ovf_clr), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag)
);

// File: tb/evt_timer_test.sv
module evt_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       cyc_tick = 1'b0, cnt_pin = 1'b0, irq_pin = 1'b0;
  logic       irq_edge, ie_set = 1'b0, ie_clr = 1'b0, ovf_clr = 1'b0;
  logic       ovf_pulse, ovf_flag;
  int         checks = 0, errors = 0, irq_hits = 0;

  always #5 clk = ~clk;

  evt_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_tick(cyc_tick),
    .cnt_pin(cnt_pin), .irq_pin(irq_pin), .irq_edge(irq_edge),
    .ie_set(ie_set), .ie_clr(ie_clr), .ovf_clr(ovf_clr),
    .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag)
  );

  always @(negedge clk) if (irq_edge) irq_hits++;

  typedef struct packed {
    logic [7:0]  ctrl;
    logic        ext;
    logic [15:0] n;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 1'b0, 16'd5,   8'd5},
    '{8'h08, 1'b0, 16'd7,   8'd3},
    '{8'h09, 1'b0, 16'd9,   8'd2},
    '{8'h0A, 1'b0, 16'd24,  8'd3},
    '{8'h0B, 1'b0, 16'd47,  8'd2},
    '{8'h0C, 1'b0, 16'd64,  8'd2},
    '{8'h0D, 1'b0, 16'd191, 8'd2},
    '{8'h0E, 1'b0, 16'd256, 8'd2},
    '{8'h0F, 1'b0, 16'd255, 8'd0},
    '{8'h0F, 1'b0, 16'd512, 8'd2},
    '{8'h20, 1'b1, 16'd4,   8'd4},
    '{8'h30, 1'b1, 16'd4,   8'd3},
    '{8'h28, 1'b1, 16'd5,   8'd2}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cyc_tick = 1'b1;
      @(negedge clk); cyc_tick = 1'b0;
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_rises(input int n);
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin cnt_pin = 1'b0; wait_cyc(5); end
      cnt_pin = 1'b1; wait_cyc(5);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    string tag;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1 reset state
    rd(1'b0, d); check("R1", d, 8'h00);
    rd(1'b1, d); check("R1", d, 8'h00);
    check("R1", {6'd0, ovf_flag, ovf_pulse}, 8'h00);

    // R2 read-only bit 6
    wr(1'b0, 8'hFF); rd(1'b0, d); check("R2", d, 8'hBF);
    // R3 set event
    @(negedge clk); ie_set = 1'b1; @(negedge clk); ie_set = 1'b0;
    rd(1'b0, d); check("R3", d, 8'hFF);
    wr(1'b0, 8'h00); rd(1'b0, d); check("R2", d, 8'h40);
    // R3 clear wins over set
    @(negedge clk); ie_set = 1'b1; ie_clr = 1'b1;
    @(negedge clk); ie_set = 1'b0; ie_clr = 1'b0;
    rd(1'b0, d); check("R3", d, 8'h00);

    // table walk: R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      wr(1'b0, VEC[v].ctrl);
      wr(1'b1, 8'h00);
      if (VEC[v].ext) begin
        cyc_tick = 1'b1;
        pin_rises(int'(VEC[v].n));
        tag = VEC[v].ctrl[4] ? "R6" : "R5";
      end else begin
        ticks(int'(VEC[v].n));
        tag = VEC[v].ctrl[3] ? "R7" : "R4";
      end
      rd(1'b1, d); check(tag, d, VEC[v].exp);
      cyc_tick = 1'b0; cnt_pin = 1'b0;
      wait_cyc(6);
    end

    // R8 wrap
    wr(1'b0, 8'h00); wr(1'b1, 8'hFE);
    ticks(1); rd(1'b1, d); check("R8", d, 8'hFF);
    check("R8", {7'd0, ovf_pulse}, 8'h00);
    @(negedge clk); cyc_tick = 1'b1;
    @(negedge clk); cyc_tick = 1'b0;
    rd(1'b1, d); check("R8", d, 8'h00);
    check("R8", {6'd0, ovf_flag, ovf_pulse}, 8'h03);
    wait_cyc(1);
    check("R8", {6'd0, ovf_flag, ovf_pulse}, 8'h02);
    @(negedge clk); ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    check("R8", {7'd0, ovf_flag}, 8'h00);
    // R8 wrap and clear in the same cycle: set wins
    wr(1'b1, 8'hFF);
    @(negedge clk); cyc_tick = 1'b1; ovf_clr = 1'b1;
    @(negedge clk); cyc_tick = 1'b0; ovf_clr = 1'b0;
    check("R8", {7'd0, ovf_flag}, 8'h01);

    // R9 load overrides increment
    wr(1'b1, 8'h10);
    @(negedge clk); cyc_tick = 1'b1; reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h50;
    @(negedge clk); cyc_tick = 1'b0; reg_wr = 1'b0;
    rd(1'b1, d); check("R9", d, 8'h50);
    // R9 write clears prescaler
    wr(1'b0, 8'h08); wr(1'b1, 8'h00);
    ticks(1); wr(1'b0, 8'h08); ticks(1);
    rd(1'b1, d); check("R9", d, 8'h00);
    ticks(1); rd(1'b1, d); check("R9", d, 8'h01);

    // R10 interrupt edge select
    wr(1'b0, 8'h00);
    irq_hits = 0; irq_pin = 1'b1; wait_cyc(6);
    check("R10", 8'(irq_hits), 8'd1);
    irq_hits = 0; irq_pin = 1'b0; wait_cyc(6);
    check("R10", 8'(irq_hits), 8'd0);
    wr(1'b0, 8'h80);
    irq_hits = 0; irq_pin = 1'b1; wait_cyc(6);
    check("R10", 8'(irq_hits), 8'd0);
    irq_hits = 0; irq_pin = 1'b0; wait_cyc(6);
    check("R10", 8'(irq_hits), 8'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule